// File: doc/BRIEF.md
# Framed SPI Master Controller

A register-mapped serial peripheral master that moves words between two small FIFOs and the four SPI wires. Software sets the bit rate, word length and clock mode in a configuration register, queues outgoing words by writing the data register, and starts a frame with a control bit. Chip select stays low while queued words go out back to back. A word carrying the end-of-frame flag closes the frame once it has shifted out. Each received word lands in the receive FIFO, and software pops it by reading the data register.

Completion, FIFO-level requests and error conditions are latched in an event register. Each event bit is cleared by writing a one to it. A mask register decides which events drive the single level-sensitive interrupt line. Register map (word index on `bus_addr`): 0 configuration, 1 control, 2 status, 3 events, 4 mask, 5 data.

Top module: `spi_frame_master`

## Requirements
- R1: After reset:
  - `spi_cs_n` is 1, `spi_sck` is 0 and `irq` is 0.
  - The event register reads 0 and the mask register reads 6'h3f.
  - The status register reads with the tx-empty and rx-empty bits set and the enable bit clear.
- R2: The serial clock half period is 2*(rate+1) module clock cycles, where rate is configuration bits [13:8]. This rate applies:
  - from chip select falling to the first clock edge;
  - between clock edges;
  - from the final clock edge to chip select rising.
- R3: Configuration bits [7:4] hold the word length minus one (7 selects 8-bit words, 15 selects 16-bit words). Words are sent most significant bit first, and the received word is right-aligned in the data register read.
- R4: Configuration bit 1 sets the idle level of `spi_sck`. Configuration bit 2 selects the sampling edge: 0 samples on the leading edge of each bit, 1 samples on the trailing edge. Every combination (modes 0 to 3) is supported.
- R5: A write to the data register queues bits [15:0] as a word and bit 16 as its end-of-frame flag. A write while the transmit FIFO holds 8 words is dropped.
- R6: The control register has three bits, each of which acts only for the cycle of the write:
  - bit 0 empties the receive FIFO;
  - bit 1 empties the transmit FIFO;
  - bit 2 starts a frame.
  A start has no effect when the block is disabled (configuration bit 0 is 0), when the transmit FIFO is empty, or when a frame is running.
- R7: Chip select goes low on an accepted start and stays low across consecutive words. After the flagged word's final clock edge it returns high half a serial clock period later, and event bit 0 (frame done) is set in that same cycle.
- R8: A data register read pops one received word. A word that arrives while the receive FIFO holds 8 words is discarded and sets event bit 3 (receive overflow).
- R9: If a word without the end-of-frame flag finishes while the transmit FIFO is empty, the block sets event bit 4 (transmit underflow) and ends the frame as in R7.
- R10: Writing a 1 to an event bit clears it. Mask bit n set to 1 blocks event n. `irq` and status bit 6 are high whenever any unmasked event is set.
- R11: While enabled, the block re-sets two request events on every cycle their condition holds:
  - Event bit 1 (transmit request) sets while the free transmit entries are at least configuration bits [19:16].
  - Event bit 2 (receive request) sets while the stored receive words are at least configuration bits [23:20].
  A threshold of 0 acts as 1.
- R12: `peer_sel_n` low while chip select is low sets event bit 5 (multiple master seen). `peer_sel_n` low while idle sets nothing.
- R13: The status register bits are:
  - bit 0: enabled;
  - bit 1: frame active;
  - bit 2: transmit FIFO full;
  - bit 3: transmit FIFO empty;
  - bit 4: receive FIFO full;
  - bit 5: receive FIFO empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |
| peer_sel_n | input | 1 | Select line of another master, active low |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 8-entry FIFOs, words of up to 16 bits and a 6-bit rate field. With these values both FIFOs fill after only eight writes or eight received words, so the dropped ninth write, the receive overflow and the full flags can all be reached in short frames. The largest rate setting (63) still fits in a few thousand cycles, so the bench measures the edge spacing at both ends of the rate range in every clock mode. The bench loops `spi_miso` back from `spi_mosi`, optionally inverted, and decodes the serial lines itself on the edge that the configured mode names.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int FIFO_DEPTH = 8,
  parameter int WORD_MAX   = 16,
  parameter int BRG_W      = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n,
  input  logic        peer_sel_n,
  output logic        irq
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int LEN_W = $clog2(WORD_MAX);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);
  localparam logic [2:0] A_CFG = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2,
                         A_EVT = 3'd3, A_MSK = 3'd4, A_DATA = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_TAIL} state_t;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic wr, rd;
  assign wr = bus_sel & bus_wr;
  assign rd = bus_sel & ~bus_wr;

  // configuration
  logic             cfg_en, cfg_cpol, cfg_cpha;
  logic [LEN_W-1:0] cfg_len;
  logic [BRG_W-1:0] cfg_brg;
  logic [CNT_W-1:0] cfg_tt, cfg_rt;
  logic [5:0]       ev, msk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_en <= 1'b0; cfg_cpol <= 1'b0; cfg_cpha <= 1'b0;
      cfg_len <= LEN_W'(7); cfg_brg <= '0; cfg_tt <= '0; cfg_rt <= '0;
      msk <= 6'h3f;
    end else begin
      if (wr && bus_addr == A_CFG) begin
        cfg_en   <= bus_wdata[0];
        cfg_cpol <= bus_wdata[1];
        cfg_cpha <= bus_wdata[2];
        cfg_len  <= bus_wdata[4 +: LEN_W];
        cfg_brg  <= bus_wdata[8 +: BRG_W];
        cfg_tt   <= bus_wdata[16 +: CNT_W];
        cfg_rt   <= bus_wdata[20 +: CNT_W];
      end
      if (wr && bus_addr == A_MSK) msk <= bus_wdata[5:0];
    end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:24], bus_wdata[15:14], bus_wdata[3]};

  // transmit FIFO
  logic [WORD_MAX:0]  tx_mem [FIFO_DEPTH];
  logic [PTR_W-1:0]   tx_wp, tx_rp;
  logic [CNT_W-1:0]   tx_cnt;
  logic               tx_push, tx_pop, tx_flush, tx_avail;
  logic [WORD_MAX:0]  tx_head;

  assign tx_push  = wr && bus_addr == A_DATA && tx_cnt != FULL;
  assign tx_flush = wr && bus_addr == A_CTRL && bus_wdata[1];
  assign tx_avail = tx_cnt != '0 && !tx_flush;
  assign tx_head  = tx_mem[tx_rp];

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[WORD_MAX:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= inc(tx_wp);
      if (tx_pop)  tx_rp <= inc(tx_rp);
      tx_cnt <= tx_cnt + CNT_W'(tx_push) - CNT_W'(tx_pop);
    end

  // receive FIFO
  logic [WORD_MAX-1:0] rx_mem [FIFO_DEPTH];
  logic [PTR_W-1:0]    rx_wp, rx_rp;
  logic [CNT_W-1:0]    rx_cnt;
  logic                rx_push, rx_pop, rx_flush, rx_ovf;
  logic [WORD_MAX-1:0] rx_word;

  assign rx_pop   = rd && bus_addr == A_DATA && rx_cnt != '0;
  assign rx_flush = wr && bus_addr == A_CTRL && bus_wdata[0];

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= inc(rx_wp);
      if (rx_pop)  rx_rp <= inc(rx_rp);
      rx_cnt <= rx_cnt + CNT_W'(rx_push) - CNT_W'(rx_pop);
    end

  // shift engine
  state_t              st;
  logic [BRG_W:0]      divcnt;
  logic [LEN_W:0]      hcnt;
  logic [WORD_MAX-1:0] sh, rsh, ld_word, rx_next;
  logic                cur_last, tick, last_edge, leading, sample_now;
  logic                start, word_end, more, underflow, frame_done;

  assign tick       = st != S_IDLE && divcnt == {cfg_brg, 1'b1};
  assign last_edge  = hcnt == {cfg_len, 1'b1};
  assign leading    = ~hcnt[0];
  assign sample_now = tick && st == S_XFER && (leading ^ cfg_cpha);
  assign rx_next    = {rsh[WORD_MAX-2:0], spi_miso};
  assign ld_word    = tx_head[WORD_MAX-1:0] << (LEN_W'(WORD_MAX - 1) - cfg_len);
  assign start      = wr && bus_addr == A_CTRL && bus_wdata[2] && st == S_IDLE
                      && cfg_en && tx_avail;
  assign word_end   = tick && st == S_XFER && last_edge;
  assign more       = !cur_last && tx_avail;
  assign underflow  = word_end && !cur_last && !tx_avail;
  assign frame_done = tick && st == S_TAIL;
  assign tx_pop     = start || (word_end && more);
  assign rx_word    = sample_now ? rx_next : rsh;
  assign rx_push    = word_end && rx_cnt != FULL;
  assign rx_ovf     = word_end && rx_cnt == FULL;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; spi_cs_n <= 1'b1; spi_sck <= 1'b0; spi_mosi <= 1'b0;
      divcnt <= '0; hcnt <= '0; sh <= '0; rsh <= '0; cur_last <= 1'b0;
    end else begin
      divcnt <= (start || tick || st == S_IDLE) ? '0 : divcnt + 1'b1;
      case (st)
        S_IDLE: begin
          spi_sck <= cfg_cpol;
          if (start) begin
            spi_cs_n <= 1'b0;
            st       <= S_XFER;
            hcnt     <= '0;
            rsh      <= '0;
            cur_last <= tx_head[WORD_MAX];
            if (!cfg_cpha) begin
              spi_mosi <= ld_word[WORD_MAX-1];
              sh       <= ld_word << 1;
            end else sh <= ld_word;
          end
        end
        S_XFER: if (tick) begin
          spi_sck <= ~spi_sck;
          hcnt    <= hcnt + 1'b1;
          if (sample_now) rsh <= rx_next;
          else begin
            spi_mosi <= sh[WORD_MAX-1];
            sh       <= sh << 1;
          end
          if (last_edge) begin
            hcnt <= '0;
            rsh  <= '0;
            if (more) begin
              cur_last <= tx_head[WORD_MAX];
              if (!cfg_cpha) begin
                spi_mosi <= ld_word[WORD_MAX-1];
                sh       <= ld_word << 1;
              end else sh <= ld_word;
            end else st <= S_TAIL;
          end
        end
        default: if (tick) begin
          spi_cs_n <= 1'b1;
          st       <= S_IDLE;
        end
      endcase
    end

  // events and interrupt
  logic [CNT_W-1:0] tt_eff, rt_eff;
  logic [5:0]       ev_set, ev_clr;
  assign tt_eff = (cfg_tt == '0) ? CNT_W'(1) : cfg_tt;
  assign rt_eff = (cfg_rt == '0) ? CNT_W'(1) : cfg_rt;
  assign ev_set = {!spi_cs_n && !peer_sel_n, underflow, rx_ovf,
                   cfg_en && rx_cnt >= rt_eff,
                   cfg_en && (FULL - tx_cnt) >= tt_eff, frame_done};
  assign ev_clr = (wr && bus_addr == A_EVT) ? bus_wdata[5:0] : 6'h0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ev <= '0;
    else        ev <= (ev & ~ev_clr) | ev_set;

  assign irq = |(ev & ~msk);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: begin
        bus_rdata[0] = cfg_en;
        bus_rdata[1] = cfg_cpol;
        bus_rdata[2] = cfg_cpha;
        bus_rdata[4 +: LEN_W]  = cfg_len;
        bus_rdata[8 +: BRG_W]  = cfg_brg;
        bus_rdata[16 +: CNT_W] = cfg_tt;
        bus_rdata[20 +: CNT_W] = cfg_rt;
      end
      A_STAT: bus_rdata[6:0] = {irq, rx_cnt == '0, rx_cnt == FULL,
                                tx_cnt == '0, tx_cnt == FULL, st != S_IDLE, cfg_en};
      A_EVT:  bus_rdata[5:0] = ev;
      A_MSK:  bus_rdata[5:0] = msk;
      A_DATA: bus_rdata[WORD_MAX-1:0] = rx_mem[rx_rp];
      default: bus_rdata = '0;
    endcase
  end

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $stable(cfg_cpol) |-> spi_sck == cfg_cpol); // R4
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL); // R5
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL); // R8
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> ev[0]); // R7
  AST_CS_FALL_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(bus_sel && bus_wr && bus_addr == A_CTRL && bus_wdata[2])); // R6
endmodule

// File: tb/test_spi_frame_master.sv
module test_spi_frame_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic spi_sck, spi_mosi, spi_miso, spi_cs_n, irq;
  logic peer_sel_n = 1'b1;
  logic inv = 1'b0;

  always #5 clk = ~clk;
  assign spi_miso = inv ? ~spi_mosi : spi_mosi;

  spi_frame_master i_spi_frame_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .peer_sel_n(peer_sel_n), .irq(irq));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // serial line monitor
  logic mon_cpol = 0, mon_cpha = 0;
  logic prev_cs = 1, prev_sck = 0;
  logic [15:0] cap;
  int cyc = 0, t_fall = 0, t_last = 0, nedge = 0, ncap = 0;
  int gap_first = 0, gap_mid = 0, gap_tail = 0;

  always @(posedge clk) begin
    cyc++;
    if (prev_cs && !spi_cs_n) begin
      t_fall = cyc; nedge = 0; ncap = 0; cap = '0;
    end
    if (!spi_cs_n && spi_sck != prev_sck) begin
      if (nedge == 0) gap_first = cyc - t_fall;
      else if (nedge == 1) gap_mid = cyc - t_last;
      if ((prev_sck == mon_cpol) ^ mon_cpha) begin
        cap = {cap[14:0], spi_mosi};
        ncap++;
      end
      t_last = cyc;
      nedge++;
    end
    if (!prev_cs && spi_cs_n) gap_tail = cyc - t_last;
    prev_cs = spi_cs_n;
    prev_sck = spi_sck;
  end

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  function automatic logic [31:0] cfgw(input logic en, input logic [1:0] mode,
      input logic [3:0] len, input logic [5:0] brg, input logic [3:0] tt, input logic [3:0] rt);
    return {8'h0, rt, tt, 2'b0, brg, len, 1'b0, mode[0], mode[1], en};
  endfunction

  task automatic wait_frame();
    while (spi_cs_n === 1'b0) @(negedge clk);
    @(negedge clk);
  endtask

  // mode[1:0] len[3:0] brg[5:0] inv data[15:0]
  localparam logic [28:0] VEC [6] = '{
    {2'd0, 4'd7,  6'd0,  1'b0, 16'h00A5},
    {2'd1, 4'd7,  6'd2,  1'b1, 16'h003C},
    {2'd2, 4'd15, 6'd1,  1'b0, 16'hBEEF},
    {2'd3, 4'd3,  6'd5,  1'b0, 16'h000D},
    {2'd1, 4'd11, 6'd0,  1'b0, 16'h0ABC},
    {2'd3, 4'd7,  6'd63, 1'b1, 16'h005A}};

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R13 reset state
    check("R1 cs_n", {31'b0, spi_cs_n}, 1);
    check("R1 sck", {31'b0, spi_sck}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    bus_read(3'd3, d); check("R1 events", d, 0);
    bus_read(3'd4, d); check("R1 mask", d, 32'h3f);
    bus_read(3'd2, d); check("R13 status reset", d, 32'h28);

    // R6 start ignored when disabled or tx empty
    bus_write(3'd0, cfgw(1, 0, 7, 0, 0, 0));
    bus_write(3'd1, 32'h4);
    repeat (4) @(negedge clk);
    check("R6 start with empty tx", {31'b0, spi_cs_n}, 1);
    bus_write(3'd0, cfgw(0, 0, 7, 0, 0, 0));
    bus_write(3'd5, 32'h1_0055);
    bus_write(3'd1, 32'h4);
    repeat (4) @(negedge clk);
    check("R6 start while disabled", {31'b0, spi_cs_n}, 1);
    bus_write(3'd1, 32'h2);
    bus_read(3'd2, d); check("R6 tx flush empties", d[3], 1);

    // R2 R3 R4 table of frames
    for (int i = 0; i < 6; i++) begin
      logic [1:0] mode; logic [3:0] len; logic [5:0] brg; logic [15:0] dat, m;
      {mode, len, brg, inv, dat} = VEC[i];
      m = 16'((32'd1 << (len + 1)) - 1);
      mon_cpol = mode[1]; mon_cpha = mode[0];
      bus_write(3'd0, cfgw(1, mode, len, brg, 0, 0));
      bus_write(3'd3, 32'h3f);
      bus_write(3'd5, {15'b0, 1'b1, dat});
      bus_write(3'd1, 32'h4);
      wait_frame();
      check($sformatf("R4 mode%0d mosi bits", mode), {16'b0, cap & m}, {16'b0, dat & m});
      check("R3 bit count", ncap, len + 1);
      check("R2 first half period", gap_first, 2 * (brg + 1));
      check("R2 edge spacing", gap_mid, 2 * (brg + 1));
      check("R2 tail half period", gap_tail, 2 * (brg + 1));
      check("R4 sck idle level", {31'b0, spi_sck}, {31'b0, mode[1]});
      bus_read(3'd3, d); check("R7 done event", d[0], 1);
      bus_read(3'd5, d); check("R3 rx word", d, {16'b0, (inv ? ~dat : dat) & m});
    end
    inv = 0;

    // R5 R7 R8: eight-word frame, ninth push dropped
    mon_cpol = 0; mon_cpha = 0;
    bus_write(3'd0, cfgw(1, 0, 7, 0, 0, 0));
    for (int k = 1; k <= 8; k++) bus_write(3'd5, {15'b0, k == 8, 8'h0, 8'(8'h10 + k)});
    bus_read(3'd2, d); check("R13 tx full", d[2], 1);
    bus_write(3'd5, 32'h1_0099);
    bus_write(3'd3, 32'h3f);
    bus_write(3'd1, 32'h4);
    @(negedge clk);
    check("R7 cs low during frame", {31'b0, spi_cs_n}, 0);
    bus_read(3'd2, d); check("R13 busy", d[1], 1);
    wait_frame();
    bus_read(3'd2, d); check("R5 ninth push dropped, tx empty", d[3], 1);
    check("R13 rx full", d[4], 1);
    bus_read(3'd3, d); check("R8 no overflow at 8", d[3], 0);
    bus_write(3'd5, 32'h1_0077);
    bus_write(3'd1, 32'h4);
    wait_frame();
    bus_read(3'd3, d); check("R8 overflow event", d[3], 1);
    for (int k = 1; k <= 8; k++) begin
      bus_read(3'd5, d); check("R8 rx order kept", d, 32'(8'h10 + k));
    end
    bus_read(3'd2, d); check("R5 R8 rx empty after reads", d[5], 1);

    // R9 underflow
    bus_write(3'd3, 32'h3f);
    bus_write(3'd5, 32'h0_0042);
    bus_write(3'd1, 32'h4);
    wait_frame();
    bus_read(3'd3, d); check("R9 underflow and done", {30'b0, d[4], d[0]}, 3);
    bus_read(3'd5, d); check("R9 word received", d, 32'h42);

    // R10 mask and irq
    bus_write(3'd3, 32'h3f);
    bus_write(3'd4, 32'h3e);
    bus_write(3'd5, 32'h1_0011);
    bus_write(3'd1, 32'h4);
    wait_frame();
    check("R10 irq on unmasked done", {31'b0, irq}, 1);
    bus_read(3'd2, d); check("R10 status irq", d[6], 1);
    bus_write(3'd3, 32'h1);
    @(negedge clk);
    check("R10 irq cleared by w1c", {31'b0, irq}, 0);
    bus_write(3'd4, 32'h3f);
    bus_read(3'd5, d);

    // R11 thresholds
    bus_write(3'd0, cfgw(1, 0, 7, 0, 8, 2));
    bus_write(3'd1, 32'h3);
    bus_write(3'd5, 32'h0_0021);
    bus_write(3'd3, 32'h3f);
    bus_read(3'd3, d); check("R11 no tx req below threshold", d[1], 0);
    check("R11 no rx req when empty", d[2], 0);
    bus_write(3'd5, 32'h1_0022);
    bus_write(3'd1, 32'h4);
    wait_frame();
    bus_write(3'd3, 32'h3f);
    bus_read(3'd3, d); check("R11 rx req at 2 words", d[2], 1);
    check("R11 tx req when free 8", d[1], 1);
    bus_read(3'd5, d);
    bus_write(3'd3, 32'h3f);
    bus_read(3'd3, d); check("R11 rx req gone at 1 word", d[2], 0);
    bus_write(3'd1, 32'h1);

    // R12 peer select
    peer_sel_n = 0;
    bus_write(3'd3, 32'h3f);
    bus_read(3'd3, d); check("R12 idle peer ignored", d[5], 0);
    bus_write(3'd5, 32'h1_0033);
    bus_write(3'd1, 32'h4);
    wait_frame();
    peer_sel_n = 1;
    bus_read(3'd3, d); check("R12 multi master flag", d[5], 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule